// File: doc/BRIEF.md
# Asynchronous Character Receiver with Error Flags

This block turns a serial line into characters. A start bit is followed by five to eight data bits, least significant first, an optional parity bit and a stop bit. The receiver counts a one-cycle sample tick, supplied from outside, at 1, 16 or 64 ticks per bit time, as a divider code selects. Each completed character is placed in a one-byte holding register, and a ready flag is raised until the host reads it.

Three error conditions are recorded in sticky flags: parity mismatch, overrun and a low stop bit. The flags stay set until the command logic pulses an error-clear input. A separate detector reports a break when the line has stayed low for two whole frame times. An enable input gates the whole receive path. The serial input is expected to be synchronous to the block clock already.

Top module: `rxa_receiver`

## Requirements
- R1: Divider code 1, 2 and 3 select 1, 16 and 64 sample ticks per bit time. Code 0 keeps the receiver idle, so no character is received.
- R2: With 16 or 64 ticks per bit, a low line seen on a tick starts a frame only if the line is still low N/2 ticks later. Each following bit is sampled every N ticks after that check. A shorter low pulse produces no character. With 1 tick per bit, the first low tick is taken as the start bit and the next tick samples data bit 0.
- R3: Length code 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, received least significant bit first. Data register bits above the selected length read 0.
- R4: When parity is enabled, one parity bit follows the data. With the even-sense input at 1, the data bits and the parity bit must hold an even number of ones; with it at 0, an odd number. A mismatch sets par_err.
- R5: On the clock edge where the stop bit is sampled, the data register takes the new character and rx_ready goes to 1.
- R6: A read strobe clears rx_ready on the next edge. If a character completes in the same cycle as the strobe, rx_ready stays 1 and no overrun is recorded.
- R7: A character that completes while rx_ready is 1, with no read strobe in that cycle, sets ovr_err and replaces the held character.
- R8: A stop bit sampled low sets frm_err.
- R9: par_err, ovr_err and frm_err stay set until an err_clr pulse. An error raised in the same cycle as err_clr remains set.
- R10: brk_det goes to 1 once the line has been low for 2·N·(data bits + parity bit + 2) consecutive ticks. It returns to 0 on the clock after the line goes high.
- R11: With rx_en low, any frame in progress is dropped and the break count is cleared. The held character, rx_ready and the error flags keep their values.
- R12: After reset, rx_data is 0 and rx_ready, par_err, ovr_err, frm_err and brk_det are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| rx_en | input | 1 | Receive enable |
| rxc_tick | input | 1 | One-cycle sample tick |
| rxd | input | 1 | Serial line, idle high |
| div_sel | input | 2 | Ticks-per-bit code (0 idle, 1 ÷1, 2 ÷16, 3 ÷64) |
| len_sel | input | 2 | Data length code (0..3 gives 5..8 bits) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 selects even parity, 0 odd |
| err_clr | input | 1 | Clears the sticky error flags |
| rd_strobe | input | 1 | Host read of the data register |
| rx_data | output | 8 | Last received character |
| rx_ready | output | 1 | Unread character held |
| par_err | output | 1 | Sticky parity error |
| ovr_err | output | 1 | Sticky overrun error |
| frm_err | output | 1 | Sticky framing error |
| brk_det | output | 1 | Break condition on the line |

## Verification
On every cycle the assertions check the flag rules: ready after a completion, clearing by a read, overrun on an unread completion, stickiness and clearing of the error flags, the break flag dropping once the line is high, and the frame logic returning to idle when disabled. Sampling position, start-bit rejection, bit order, length masking and parity sense depend on whole waveforms. Only the bench's scenarios can show them, by comparing the outputs each clock against a behavioural model while different dividers, lengths, parity settings, glitches, breaks and mid-frame disables are applied.

// File: rtl/rxa_pkg.sv
`timescale 1ns/1ps
package rxa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    localparam logic [1:0] DIV_OFF = 2'd0;
    localparam logic [1:0] DIV_X1  = 2'd1;
    localparam logic [1:0] DIV_MID = 2'd2;
    localparam logic [1:0] DIV_HI  = 2'd3;

endpackage

// File: rtl/rxa_frame.sv
`timescale 1ns/1ps
module rxa_frame
    import rxa_pkg::*;
#(
    parameter int CHAR_MAX = 8,
    parameter int OVS_MID  = 16,
    parameter int OVS_HI   = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                tick,
    input  logic                rxd,
    input  logic [1:0]          div_sel,
    input  logic [1:0]          len_sel,
    input  logic                par_en,
    input  logic                par_even,
    output logic                done,
    output logic [CHAR_MAX-1:0] char_o,
    output logic                perr_o,
    output logic                ferr_o
);

    localparam int CNT_W    = $clog2(OVS_HI);
    localparam int IDX_W    = $clog2(CHAR_MAX);
    localparam int CHAR_MIN = CHAR_MAX - 3;

    typedef struct packed {
        rx_state_e           st;
        logic [CNT_W-1:0]    cnt;
        logic [IDX_W-1:0]    idx;
        logic [CHAR_MAX-1:0] sh;
        logic                pbit;
    } frame_s;

    frame_s fr_d, fr_q;

    logic [CNT_W-1:0] last_tick;
    logic [CNT_W-1:0] half_tick;
    logic [IDX_W-1:0] last_idx;
    logic             bit_pt;

    always_comb begin
        case (div_sel)
            DIV_X1:  begin last_tick = '0;                  half_tick = '0; end
            DIV_MID: begin last_tick = CNT_W'(OVS_MID - 1); half_tick = CNT_W'(OVS_MID / 2 - 1); end
            default: begin last_tick = CNT_W'(OVS_HI - 1);  half_tick = CNT_W'(OVS_HI / 2 - 1); end
        endcase
        last_idx = IDX_W'(CHAR_MIN - 1) + IDX_W'(len_sel);
        bit_pt   = (fr_q.cnt == last_tick);
    end

    always_comb begin
        fr_d = fr_q;
        done = 1'b0;
        if (!active) begin
            fr_d.st  = ST_IDLE;
            fr_d.cnt = '0;
        end else if (tick) begin
            case (fr_q.st)
                ST_IDLE: begin
                    if (!rxd) begin
                        fr_d.cnt = '0;
                        fr_d.idx = '0;
                        fr_d.sh  = '0;
                        fr_d.st  = (div_sel == DIV_X1) ? ST_DATA : ST_START;
                    end
                end
                ST_START: begin
                    if (fr_q.cnt == half_tick) begin
                        fr_d.cnt = '0;
                        fr_d.st  = rxd ? ST_IDLE : ST_DATA;
                    end else begin
                        fr_d.cnt = fr_q.cnt + CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (bit_pt) begin
                        fr_d.cnt         = '0;
                        fr_d.sh[fr_q.idx] = rxd;
                        if (fr_q.idx == last_idx) begin
                            fr_d.st = par_en ? ST_PAR : ST_STOP;
                        end else begin
                            fr_d.idx = fr_q.idx + IDX_W'(1);
                        end
                    end else begin
                        fr_d.cnt = fr_q.cnt + CNT_W'(1);
                    end
                end
                ST_PAR: begin
                    if (bit_pt) begin
                        fr_d.cnt  = '0;
                        fr_d.pbit = rxd;
                        fr_d.st   = ST_STOP;
                    end else begin
                        fr_d.cnt = fr_q.cnt + CNT_W'(1);
                    end
                end
                ST_STOP: begin
                    if (bit_pt) begin
                        fr_d.cnt = '0;
                        fr_d.st  = ST_IDLE;
                        done     = 1'b1;
                    end else begin
                        fr_d.cnt = fr_q.cnt + CNT_W'(1);
                    end
                end
                default: fr_d.st = ST_IDLE;
            endcase
        end
    end

    // Bits above the selected length were cleared at the start bit.
    assign char_o = fr_q.sh;
    assign perr_o = par_en & ((^fr_q.sh) ^ fr_q.pbit ^ ~par_even);
    assign ferr_o = ~rxd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '{st: ST_IDLE, cnt: '0, idx: '0, sh: '0, pbit: 1'b0};
        end else begin
            fr_q <= fr_d;
        end
    end

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (fr_q.st == ST_IDLE)); // R11

endmodule

// File: rtl/rxa_break.sv
`timescale 1ns/1ps
module rxa_break
    import rxa_pkg::*;
#(
    parameter int CHAR_MAX = 8,
    parameter int OVS_MID  = 16,
    parameter int OVS_HI   = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] div_sel,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    output logic       brk
);

    localparam int CHAR_MIN = CHAR_MAX - 3;
    localparam int LIM_MAX  = 2 * OVS_HI * (CHAR_MAX + 3);
    localparam int CW       = $clog2(LIM_MAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } brk_s;

    brk_s bk_d, bk_q;

    logic [CW-1:0] ovs_w;
    logic [CW-1:0] frame_w;
    logic [CW-1:0] lim;

    always_comb begin
        case (div_sel)
            DIV_X1:  ovs_w = CW'(1);
            DIV_MID: ovs_w = CW'(OVS_MID);
            default: ovs_w = CW'(OVS_HI);
        endcase
        frame_w = CW'(CHAR_MIN) + CW'(len_sel) + CW'(par_en) + CW'(2);
        lim     = CW'(2) * ovs_w * frame_w;
    end

    always_comb begin
        bk_d = bk_q;
        if (!active || rxd) begin
            bk_d.cnt = '0;
        end else if (tick && (bk_q.cnt < lim)) begin
            bk_d.cnt = bk_q.cnt + CW'(1);
        end
    end

    assign brk = (bk_q.cnt >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '{cnt: '0};
        end else begin
            bk_q <= bk_d;
        end
    end

    AST_BRK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rxd |=> !brk); // R10
    AST_BRK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !brk); // R11

endmodule

// File: rtl/rxa_hold.sv
`timescale 1ns/1ps
module rxa_hold #(
    parameter int CHAR_MAX = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done,
    input  logic [CHAR_MAX-1:0] char_i,
    input  logic                perr_i,
    input  logic                ferr_i,
    input  logic                rd,
    input  logic                err_clr,
    output logic [CHAR_MAX-1:0] data_o,
    output logic                ready_o,
    output logic                perr_o,
    output logic                oerr_o,
    output logic                ferr_o
);

    typedef struct packed {
        logic [CHAR_MAX-1:0] data;
        logic                ready;
        logic                pe;
        logic                oe;
        logic                fe;
    } hold_s;

    hold_s hd_d, hd_q;

    always_comb begin
        hd_d = hd_q;
        if (err_clr) begin
            hd_d.pe = 1'b0;
            hd_d.oe = 1'b0;
            hd_d.fe = 1'b0;
        end
        if (rd) begin
            hd_d.ready = 1'b0;
        end
        if (done) begin
            hd_d.data  = char_i;
            hd_d.ready = 1'b1;
            hd_d.pe    = hd_d.pe | perr_i;
            hd_d.fe    = hd_d.fe | ferr_i;
            hd_d.oe    = hd_d.oe | (hd_q.ready & ~rd);
        end
    end

    assign data_o  = hd_q.data;
    assign ready_o = hd_q.ready;
    assign perr_o  = hd_q.pe;
    assign oerr_o  = hd_q.oe;
    assign ferr_o  = hd_q.fe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hd_q <= '{data: '0, ready: 1'b0, pe: 1'b0, oe: 1'b0, fe: 1'b0};
        end else begin
            hd_q <= hd_d;
        end
    end

    AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready_o); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> !ready_o); // R6
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ready_o && !rd) |=> oerr_o); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_clr && (perr_o || oerr_o || ferr_o)) |=> (perr_o || oerr_o || ferr_o)); // R9
    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !done) |=> !(perr_o || oerr_o || ferr_o)); // R9

endmodule

// File: rtl/rxa_receiver.sv
`timescale 1ns/1ps
module rxa_receiver
    import rxa_pkg::*;
#(
    parameter int CHAR_MAX = 8,
    parameter int OVS_MID  = 16,
    parameter int OVS_HI   = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_en,
    input  logic                rxc_tick,
    input  logic                rxd,
    input  logic [1:0]          div_sel,
    input  logic [1:0]          len_sel,
    input  logic                par_en,
    input  logic                par_even,
    input  logic                err_clr,
    input  logic                rd_strobe,
    output logic [CHAR_MAX-1:0] rx_data,
    output logic                rx_ready,
    output logic                par_err,
    output logic                ovr_err,
    output logic                frm_err,
    output logic                brk_det
);

    logic                active;
    logic                fr_done;
    logic [CHAR_MAX-1:0] fr_char;
    logic                fr_perr;
    logic                fr_ferr;

    assign active = rx_en & (div_sel != DIV_OFF);

    rxa_frame #(
        .CHAR_MAX (CHAR_MAX),
        .OVS_MID  (OVS_MID),
        .OVS_HI   (OVS_HI)
    ) frame_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tick     (rxc_tick),
        .rxd      (rxd),
        .div_sel  (div_sel),
        .len_sel  (len_sel),
        .par_en   (par_en),
        .par_even (par_even),
        .done     (fr_done),
        .char_o   (fr_char),
        .perr_o   (fr_perr),
        .ferr_o   (fr_ferr)
    );

    rxa_hold #(
        .CHAR_MAX (CHAR_MAX)
    ) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (fr_done),
        .char_i  (fr_char),
        .perr_i  (fr_perr),
        .ferr_i  (fr_ferr),
        .rd      (rd_strobe),
        .err_clr (err_clr),
        .data_o  (rx_data),
        .ready_o (rx_ready),
        .perr_o  (par_err),
        .oerr_o  (ovr_err),
        .ferr_o  (frm_err)
    );

    rxa_break #(
        .CHAR_MAX (CHAR_MAX),
        .OVS_MID  (OVS_MID),
        .OVS_HI   (OVS_HI)
    ) break_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .tick    (rxc_tick),
        .rxd     (rxd),
        .div_sel (div_sel),
        .len_sel (len_sel),
        .par_en  (par_en),
        .brk     (brk_det)
    );

endmodule

// File: tb/rxa_receiver_tb_top.sv
`timescale 1ns/1ps
module rxa_receiver_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       rxc_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] div_sel = 2'd2;
    logic [1:0] len_sel = 2'd3;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       err_clr = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, par_err, ovr_err, frm_err, brk_det;

    int n_chk = 0;
    int n_err = 0;
    int tper = 1;
    int tcnt = 0;
    bit cmp_on = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rxa_receiver dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxc_tick(rxc_tick), .rxd(rxd),
        .div_sel(div_sel), .len_sel(len_sel), .par_en(par_en), .par_even(par_even),
        .err_clr(err_clr), .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_ready(rx_ready),
        .par_err(par_err), .ovr_err(ovr_err), .frm_err(frm_err), .brk_det(brk_det)
    );

    // tick generator: one pulse every tper cycles
    always @(negedge clk) begin
        if (tper <= 1) rxc_tick = 1'b1;
        else begin
            rxc_tick = (tcnt == 0);
            tcnt = (tcnt + 1) % tper;
        end
    end

    function automatic int ovs_of(input logic [1:0] c);
        return (c == 2'd1) ? 1 : (c == 2'd2) ? 16 : 64;
    endfunction

    function automatic int brk_limit();
        return 2 * ovs_of(div_sel) * (int'(len_sel) + 5 + int'(par_en) + 2);
    endfunction

    // behavioural reference model
    int m_ph, m_t, m_k, m_bc;
    bit m_bits [0:15];
    bit [7:0] e_data;
    bit e_rdy, e_pe, e_oe, e_fe;

    always @(posedge clk) begin
        int n, nb, tot;
        bit fin, pv, sv;
        bit [7:0] ch;
        if (!rst_n) begin
            m_ph = 0; m_t = 0; m_k = 0; m_bc = 0;
            e_data = 0; e_rdy = 0; e_pe = 0; e_oe = 0; e_fe = 0;
        end else begin
            n = ovs_of(div_sel); nb = int'(len_sel) + 5; tot = nb + int'(par_en) + 1;
            fin = 0; pv = 0; sv = 1; ch = 0;
            if (!rx_en || div_sel == 2'd0) begin
                m_ph = 0; m_bc = 0;
            end else begin
                if (rxd) m_bc = 0;
                else if (rxc_tick && m_bc < brk_limit()) m_bc++;
                if (rxc_tick) begin
                    if (m_ph == 0) begin
                        if (!rxd) begin
                            m_t = 0; m_k = 0;
                            m_ph = (n == 1) ? 2 : 1;
                        end
                    end else if (m_ph == 1) begin
                        m_t++;
                        if (m_t == n / 2) begin
                            m_t = 0; m_k = 0;
                            m_ph = rxd ? 0 : 2;
                        end
                    end else begin
                        m_t++;
                        if (m_t == n) begin
                            m_t = 0;
                            m_bits[m_k] = rxd;
                            m_k++;
                            if (m_k == tot) begin
                                fin = 1; m_ph = 0;
                                for (int i = 0; i < nb; i++) ch[i] = m_bits[i];
                                pv = m_bits[nb];
                                sv = rxd;
                            end
                        end
                    end
                end
            end
            if (err_clr) begin e_pe = 0; e_oe = 0; e_fe = 0; end
            if (fin) begin
                e_oe = e_oe | (e_rdy & !rd_strobe);
                e_data = ch; e_rdy = 1;
                e_pe = e_pe | (par_en & ((^ch) ^ pv ^ !par_even));
                e_fe = e_fe | !sv;
            end else if (rd_strobe) e_rdy = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            chk("R5 model data",    int'(rx_data),  int'(e_data));
            chk("R6 model ready",   int'(rx_ready), int'(e_rdy));
            chk("R4 model par_err", int'(par_err),  int'(e_pe));
            chk("R7 model ovr_err", int'(ovr_err),  int'(e_oe));
            chk("R8 model frm_err", int'(frm_err),  int'(e_fe));
            chk("R10 model brk",    int'(brk_det),  int'(m_bc >= brk_limit()));
        end
    end

    task automatic drive_bit(input logic v, input int cyc);
        @(negedge clk) rxd = v;
        repeat (cyc - 1) @(negedge clk);
    endtask

    task automatic send_frame(input int nb, input logic [7:0] dv, input bit pen,
                              input bit pval, input bit sval);
        int bt;
        bt = ovs_of(div_sel) * tper;
        drive_bit(1'b0, bt);
        for (int i = 0; i < nb; i++) drive_bit(dv[i], bt);
        if (pen) drive_bit(pval, bt);
        drive_bit(sval, bt);
        drive_bit(1'b1, 2 * bt);
    endtask

    task automatic pulse_rd();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
    endtask

    task automatic idle(input int cyc);
        @(negedge clk) rxd = 1'b1;
        repeat (cyc) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R12 reset state
        chk("R12 data",  int'(rx_data), 0);
        chk("R12 ready", int'(rx_ready), 0);
        chk("R12 flags", int'({par_err, ovr_err, frm_err, brk_det}), 0);
        rst_n = 1'b1;
        cmp_on = 1;
        rx_en = 1'b1;
        idle(4);

        // R1 divide by 16, 8 bits
        send_frame(8, 8'hA5, 0, 0, 1);
        chk("R1 div16 data", int'(rx_data), 8'hA5);
        chk("R5 ready set", int'(rx_ready), 1);
        pulse_rd();
        chk("R6 ready cleared by read", int'(rx_ready), 0);

        // R1 divide by 64
        div_sel = 2'd3;
        send_frame(8, 8'h3C, 0, 0, 1);
        chk("R1 div64 data", int'(rx_data), 8'h3C);
        pulse_rd();

        // R1 divide by 1, tick every 4 cycles
        div_sel = 2'd1; tper = 4;
        idle(8);
        send_frame(8, 8'h96, 0, 0, 1);
        chk("R1 div1 data", int'(rx_data), 8'h96);
        pulse_rd();
        tper = 1; div_sel = 2'd2;
        idle(8);

        // R3 short characters
        len_sel = 2'd0;
        send_frame(5, 8'h1F, 0, 0, 1);
        chk("R3 5-bit upper zero", int'(rx_data), 8'h1F);
        pulse_rd();
        len_sel = 2'd1;
        send_frame(6, 8'h2A, 0, 0, 1);
        chk("R3 6-bit data", int'(rx_data), 8'h2A);
        pulse_rd();

        // R4 parity (even sense: bit = xor of data)
        len_sel = 2'd3; par_en = 1'b1; par_even = 1'b1;
        send_frame(8, 8'h0F, 1, 1'b0, 1);
        chk("R4 good even parity", int'(par_err), 0);
        send_frame(8, 8'h07, 1, 1'b0, 1);
        chk("R4 bad even parity", int'(par_err), 1);
        pulse_rd();
        par_even = 1'b0;
        send_frame(8, 8'h03, 1, 1'b1, 1);
        chk("R9 parity flag sticky", int'(par_err), 1);
        chk("R4 odd parity data", int'(rx_data), 8'h03);
        pulse_clr();
        chk("R9 flags cleared", int'({par_err, ovr_err, frm_err}), 0);
        pulse_rd();
        par_en = 1'b0;

        // R7 overrun
        pulse_clr();
        send_frame(8, 8'h11, 0, 0, 1);
        send_frame(8, 8'h22, 0, 0, 1);
        chk("R7 overrun flag", int'(ovr_err), 1);
        chk("R7 newest data kept", int'(rx_data), 8'h22);
        pulse_rd();
        pulse_clr();

        // R8 framing
        send_frame(8, 8'h55, 0, 0, 0);
        chk("R8 framing flag", int'(frm_err), 1);
        idle(16 * 12);
        pulse_rd();
        pulse_clr();

        // R2 glitch rejection
        chk("R2 ready before glitch", int'(rx_ready), 0);
        @(negedge clk) rxd = 1'b0;
        repeat (4) @(negedge clk);
        idle(16 * 12);
        chk("R2 short low ignored", int'(rx_ready), 0);

        // R10 break
        @(negedge clk) rxd = 1'b0;
        repeat (400) @(negedge clk);
        chk("R10 break detected", int'(brk_det), 1);
        @(negedge clk) rxd = 1'b1;
        @(negedge clk);
        chk("R10 break released", int'(brk_det), 0);
        idle(16 * 12);
        pulse_rd();
        pulse_clr();

        // R11 disable mid frame
        send_frame(8, 8'h5A, 0, 0, 1);
        pulse_rd();
        drive_bit(1'b0, 16);
        drive_bit(1'b1, 16);
        drive_bit(1'b0, 16);
        @(negedge clk) rx_en = 1'b0;
        idle(40);
        @(negedge clk) rx_en = 1'b1;
        idle(16 * 12);
        chk("R11 aborted frame no ready", int'(rx_ready), 0);
        chk("R11 held data kept", int'(rx_data), 8'h5A);

        // R1 code 0 keeps receiver idle
        div_sel = 2'd0;
        send_frame(8, 8'hC3, 0, 0, 1);
        chk("R1 code0 no char", int'(rx_ready), 0);
        div_sel = 2'd2;
        idle(8);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule